// File: doc/BRIEF.md
# Signed Four-Way Dot-Product Accumulator

This block is a vector multiply-accumulate datapath. Three vectors of `VEC_W` bits each arrive with one transfer: two sources and an accumulator. A 2-bit size code splits the vectors into lanes. In each lane the block multiplies four pairs of narrow signed sub-elements, adds the four products together, and adds that sum to the matching accumulator lane. It returns the whole updated vector.

Code `2'b10` gives 32-bit lanes, each made of four signed bytes. Code `2'b11` gives 64-bit lanes, each made of four signed 16-bit halfwords. Codes whose upper bit is zero are illegal. For an illegal code the block returns the accumulator unchanged and raises an undefined-operation flag with that result.

Transfers use valid/ready handshakes on both sides. The first stage forms all products. The second stage reduces the products and accumulates. Both stages stall cleanly when the consumer applies backpressure.

Top module: `qdot_acc`

## Requirements
- R1: With `size_i = 2'b10`, lane e covers bits [32e+31:32e]. Its result is acc lane + the sum, for i = 0..3, of the product of byte (4e+i) of `src_a_i` and byte (4e+i) of `src_b_i`. Byte k occupies bits [8k+7:8k].
- R2: With `size_i = 2'b11`, lane e covers bits [64e+63:64e]. Its result is acc lane + the sum, for i = 0..3, of the product of halfword (4e+i) of `src_a_i` and halfword (4e+i) of `src_b_i`. Halfword k occupies bits [16k+15:16k].
- R3: All sub-elements are two's-complement signed. For example, 0x80 times 0x80 gives +16384, and 0xFF times 0x01 gives -1.
- R4: Every lane of the vector is updated in every legal operation; there is no per-lane masking.
- R5: Each lane sum wraps modulo 2^(lane width). No saturation is applied, and lanes do not carry into each other.
- R6: With `size_i` equal to `2'b00` or `2'b01`, `undef_o` is 1 with that result, and `result_o` equals the `acc_i` that was supplied.
- R7: With a legal size code, `undef_o` is 0 with the result.
- R8: When the output is not stalled, a transfer accepted at clock edge k produces `out_valid_o` after edge k+1.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `result_o` and `undef_o` hold. Results leave in acceptance order, and none is dropped or duplicated.
- R10: After reset, `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input transfer valid |
| in_ready_o | output | 1 | Block can accept an input transfer |
| size_i | input | 2 | Lane size code |
| src_a_i | input | VEC_W | First source vector |
| src_b_i | input | VEC_W | Second source vector |
| acc_i | input | VEC_W | Accumulator vector |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer accepts the result |
| result_o | output | VEC_W | Updated accumulator vector |
| undef_o | output | 1 | Illegal size code flag for this result |

## Verification
A stage-1 register that holds the wrong mode bit shows up in the very next result. Every lane comes out combined at the wrong granularity, so extreme operands such as all-0x80 bytes make the error plain within two cycles of acceptance. A stale or lost valid bit in the pipeline shows at the output as a missing, repeated or reordered result. Random backpressure combined with an in-order scoreboard catches this by the next transfer that completes. A product or accumulator chunk placed at the wrong position corrupts only some lanes, so one-hot operand patterns are used to show exactly which lane is affected.

// File: rtl/qdot_pkg.sv
package qdot_pkg;
  localparam int CHUNK_W = 64;
  localparam int PROD_W  = 2 * CHUNK_W;

  typedef enum logic [1:0] {
    SZ_RSV0 = 2'b00,
    SZ_RSV1 = 2'b01,
    SZ_W32  = 2'b10,
    SZ_W64  = 2'b11
  } size_e;

  function automatic logic size_legal(input logic [1:0] sz);
    return sz[1];
  endfunction
endpackage

// File: rtl/qdot_mul.sv
// Stage-1 products for one 64-bit chunk; packs byte or halfword products into 128 bits.
module qdot_mul
  import qdot_pkg::*;
(
  input  logic [CHUNK_W-1:0] a_i,
  input  logic [CHUNK_W-1:0] b_i,
  input  logic               wide_i,
  output logic [PROD_W-1:0]  prod_o
);
  localparam int NB = CHUNK_W / 8;
  localparam int NH = CHUNK_W / 16;

  logic [PROD_W-1:0] p8_flat, p16_flat;

  for (genvar j = 0; j < NB; j++) begin : g_byte
    logic signed [15:0] p;
    assign p = $signed(a_i[8*j +: 8]) * $signed(b_i[8*j +: 8]);
    assign p8_flat[16*j +: 16] = p;
  end

  for (genvar k = 0; k < NH; k++) begin : g_half
    logic signed [31:0] p;
    assign p = $signed(a_i[16*k +: 16]) * $signed(b_i[16*k +: 16]);
    assign p16_flat[32*k +: 32] = p;
  end

  assign prod_o = wide_i ? p16_flat : p8_flat;
endmodule

// File: rtl/qdot_reduce.sv
// Stage-2 reduction and accumulation for one 64-bit chunk.
module qdot_reduce
  import qdot_pkg::*;
(
  input  logic [PROD_W-1:0]  prod_i,
  input  logic [CHUNK_W-1:0] acc_i,
  input  logic               wide_i,
  input  logic               legal_i,
  output logic [CHUNK_W-1:0] res_o
);
  logic [63:0] sum64;
  logic [31:0] sum32 [2];

  always_comb begin
    sum64 = acc_i;
    for (int i = 0; i < 4; i++) begin
      sum64 = sum64 + {{32{prod_i[32*i+31]}}, prod_i[32*i +: 32]};
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_lane32
    always_comb begin
      sum32[h] = acc_i[32*h +: 32];
      for (int i = 0; i < 4; i++) begin
        sum32[h] = sum32[h] + {{16{prod_i[16*(4*h+i)+15]}}, prod_i[16*(4*h+i) +: 16]};
      end
    end
  end

  always_comb begin
    if (!legal_i)     res_o = acc_i;
    else if (wide_i)  res_o = sum64;
    else              res_o = {sum32[1], sum32[0]};
  end
endmodule

// File: rtl/qdot_acc.sv
module qdot_acc
  import qdot_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [1:0]       size_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  input  logic [VEC_W-1:0] acc_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [VEC_W-1:0] result_o,
  output logic             undef_o
);
  localparam int NCH = VEC_W / CHUNK_W;

  // stage 1
  logic                  s1_vld_q, s1_wide_q, s1_legal_q;
  logic [NCH*PROD_W-1:0] s1_prod_q, prod_d;
  logic [VEC_W-1:0]      s1_acc_q;
  // stage 2
  logic                  s2_vld_q, s2_undef_q;
  logic [VEC_W-1:0]      s2_res_q, res_d;

  logic s1_adv, s2_adv, in_fire;

  assign s2_adv     = !s2_vld_q || out_ready_i;
  assign s1_adv     = !s1_vld_q || s2_adv;
  assign in_ready_o = s1_adv;
  assign in_fire    = in_valid_i && in_ready_o;

  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    qdot_mul u_mul (
      .a_i   (src_a_i[CHUNK_W*c +: CHUNK_W]),
      .b_i   (src_b_i[CHUNK_W*c +: CHUNK_W]),
      .wide_i(size_i[0]),
      .prod_o(prod_d[PROD_W*c +: PROD_W])
    );
    qdot_reduce u_red (
      .prod_i (s1_prod_q[PROD_W*c +: PROD_W]),
      .acc_i  (s1_acc_q[CHUNK_W*c +: CHUNK_W]),
      .wide_i (s1_wide_q),
      .legal_i(s1_legal_q),
      .res_o  (res_d[CHUNK_W*c +: CHUNK_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q   <= 1'b0;
      s1_wide_q  <= 1'b0;
      s1_legal_q <= 1'b0;
      s1_prod_q  <= '0;
      s1_acc_q   <= '0;
    end else if (s1_adv) begin
      s1_vld_q <= in_valid_i;
      if (in_valid_i) begin
        s1_wide_q  <= size_i[0];
        s1_legal_q <= size_legal(size_i);
        s1_prod_q  <= prod_d;
        s1_acc_q   <= acc_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld_q   <= 1'b0;
      s2_undef_q <= 1'b0;
      s2_res_q   <= '0;
    end else if (s2_adv) begin
      s2_vld_q <= s1_vld_q;
      if (s1_vld_q) begin
        s2_undef_q <= !s1_legal_q;
        s2_res_q   <= res_d;
      end
    end
  end

  assign out_valid_o = s2_vld_q;
  assign result_o    = s2_res_q;
  assign undef_o     = s2_vld_q && s2_undef_q;

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o) && $stable(undef_o)); // R9
  AST_ACCEPT_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire |=> s1_vld_q); // R8
  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld_q && s2_vld_q && !out_ready_i |-> !in_ready_o); // R9
  AST_UNDEF_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> out_valid_o); // R6
  AST_S1_TO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld_q && s2_adv |=> out_valid_o); // R8
endmodule

// File: tb/qdot_acc_bench.sv
`timescale 1ns/1ps
module qdot_acc_bench;
  localparam int VEC_W = 128;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [1:0]       size = 2'b10;
  logic [VEC_W-1:0] src_a = '0, src_b = '0, acc = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [VEC_W-1:0] result;
  logic             undef;

  int total = 0, bad = 0, cyc = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [VEC_W-1:0] res;
    logic             und;
    int               acc_cyc;
    bit               lat_chk;
    string            tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qdot_acc #(.VEC_W(VEC_W)) u_qdot_acc (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .size_i(size), .src_a_i(src_a), .src_b_i(src_b), .acc_i(acc),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .result_o(result), .undef_o(undef)
  );

  function automatic logic [VEC_W-1:0] ref_dot(input logic [1:0] sz,
      input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b, input logic [VEC_W-1:0] c);
    logic [VEC_W-1:0] r;
    logic [63:0] s;
    longint p;
    r = c;
    if (sz == 2'b10) begin
      for (int e = 0; e < VEC_W/32; e++) begin
        s = {32'd0, c[32*e +: 32]};
        for (int i = 0; i < 4; i++) begin
          p = $signed(a[8*(4*e+i) +: 8]) * $signed(b[8*(4*e+i) +: 8]);
          s = s + 64'(p);
        end
        r[32*e +: 32] = s[31:0];
      end
    end else if (sz == 2'b11) begin
      for (int e = 0; e < VEC_W/64; e++) begin
        s = c[64*e +: 64];
        for (int i = 0; i < 4; i++) begin
          p = $signed(a[16*(4*e+i) +: 16]) * $signed(b[16*(4*e+i) +: 16]);
          s = s + 64'(p);
        end
        r[64*e +: 64] = s;
      end
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] rnd_vec();
    logic [VEC_W-1:0] v;
    for (int w = 0; w < VEC_W/32; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] sz, input logic [VEC_W-1:0] a,
                      input logic [VEC_W-1:0] b, input logic [VEC_W-1:0] c,
                      input bit lat, input string tag);
    item_t it;
    int rec;
    it.res = ref_dot(sz, a, b, c);
    it.und = !sz[1];
    it.lat_chk = lat;
    it.tag = tag;
    forever begin
      @(negedge clk);
      in_valid = 1'b1; size = sz; src_a = a; src_b = b; acc = c;
      #1;
      if (in_ready) begin
        rec = cyc;
        @(posedge clk);
        it.acc_cyc = rec;
        sb.push_back(it);
        #1 in_valid = 1'b0;
        break;
      end
    end
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    bit prev_stall = 1'b0;
    logic [VEC_W-1:0] prev_res = '0;
    logic prev_und = 1'b0;
    item_t it;
    @(posedge rst_ni);
    forever begin
      @(negedge clk);
      out_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (prev_stall) begin
        check(out_valid && result == prev_res && undef == prev_und, "R9",
              "hold under stall", result, prev_res);
      end
      prev_stall = out_valid && !out_ready;
      prev_res = result;
      prev_und = undef;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9", "unexpected result", result, '0);
        end else begin
          it = sb.pop_front();
          check(result == it.res, it.tag, "result", result, it.res);
          check(undef == it.und, it.und ? "R6" : "R7", "undef flag",
                VEC_W'(undef), VEC_W'(it.und));
          if (it.lat_chk)
            check(cyc == it.acc_cyc + 2, "R8", "latency",
                  VEC_W'(cyc - it.acc_cyc), VEC_W'(2));
        end
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [VEC_W-1:0] a, b;
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1'b1, "R10", "in_ready in reset", VEC_W'(in_ready), VEC_W'(1));
    check(out_valid == 1'b0, "R10", "out_valid in reset", VEC_W'(out_valid), VEC_W'(0));
    rst_ni = 1'b1;
    @(negedge clk); #1;
    check(in_ready == 1'b1 && out_valid == 1'b0, "R10", "idle after reset",
          VEC_W'({in_ready, out_valid}), VEC_W'(2'b10));

    // R3 extreme bytes: each lane += 65536
    send(2'b10, {16{8'h80}}, {16{8'h80}}, '0, 1'b1, "R3");
    drain();
    // R5 wrap in 32-bit lanes, no carry across lanes
    send(2'b10, {16{8'h7f}}, {16{8'h7f}}, {4{32'h7fff_ffff}}, 1'b1, "R5");
    drain();
    send(2'b10, {16{8'h01}}, {16{8'h01}}, {4{32'hffff_fffe}}, 1'b1, "R5");
    drain();
    // R2 extreme halfwords, and R5 wrap in 64-bit lanes
    send(2'b11, {8{16'h8000}}, {8{16'h8000}}, '0, 1'b1, "R2");
    drain();
    send(2'b11, {8{16'h8000}}, {8{16'h8000}}, {2{64'hffff_ffff_ffff_ffff}}, 1'b1, "R5");
    drain();
    // R3 negative times positive
    send(2'b10, {16{8'hff}}, {16{8'h01}}, '0, 1'b1, "R3");
    drain();
    // R1 positional pairing: distinct bytes against one-hot
    for (int k = 0; k < 16; k++) begin
      a = '0;
      for (int j = 0; j < 16; j++) a[8*j +: 8] = 8'(j + 1);
      b = '0; b[8*k +: 8] = 8'h03;
      send(2'b10, a, b, {4{32'h1000}}, 1'b0, "R1");
    end
    for (int k = 0; k < 8; k++) begin
      a = '0;
      for (int j = 0; j < 8; j++) a[16*j +: 16] = 16'(j * 257 + 1);
      b = '0; b[16*k +: 16] = 16'hfffe;
      send(2'b11, a, b, '0, 1'b0, "R2");
    end
    // R6 illegal codes return accumulator
    send(2'b00, rnd_vec(), rnd_vec(), rnd_vec(), 1'b1, "R6");
    drain();
    send(2'b01, rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, "R6");
    // R4 every lane updated with random data
    for (int n = 0; n < 20; n++)
      send(2'b10 | 2'(n & 1), rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, "R4");
    drain();
    // R9 random backpressure with mixed codes
    stall_en = 1'b1;
    for (int n = 0; n < 300; n++)
      send(2'($urandom_range(0, 3)), rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, "R9");
    drain();
    stall_en = 1'b0;
    drain();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule